// File: doc/BRIEF.md
# Submodule switching-pattern frame packer

This block takes the gate commands for every submodule of a modular multilevel converter arm set and turns them into a stream of fixed-length 32-bit word frames for a serial link. Each submodule owns a nibble of four switch bits. Eight submodules share one payload word, 32 payload words follow a single header word, and the 1024-submodule default is therefore spread over four frames. Each frame occupies one time slot of `SLOT_CYCLES` clocks, which is one microsecond at the intended clock rate. The four frames of a round are sent back to back and the rounds repeat without a break.

A load strobe captures the whole command vector together with a topology selector. The selector clears the switch bits that the chosen submodule type does not have. The captured copy is handed to the transmit side only at the start of a round, so a round never mixes two command sets. Submodules above the configured count are always sent as zero, which means every switch is off.

Top module: `swp_frame_packer`

## Requirements
- R1: The first word of every frame is a header with `sof_o` high, and `sof_o` is low on all other words. Bits [31:20] of the header hold `BASE_ADDR` plus the frame index. Bits [19:8] hold the frame length of 33 words. Bits [7:0] hold `VERSION`.
- R2: Payload word w (1 to 32) of frame f carries the submodules j = f*256 + (w-1)*8 + k for k = 0 to 7 (0-based). Submodule k sits in bits [4k+3:4k], and its switch n (1 to 4) is bit 4k+n-1. Submodule j is taken from `gate_i[4j+3:4j]`.
- R3: With `topo_i` = 0 (full bridge), all four switch bits of each submodule are passed through.
- R4: With `topo_i` = 1 (half bridge), only switches 1 and 2 are passed through. Switches 3 and 4 are sent as 0 whatever the command.
- R5: With `topo_i` = 2 (half bridge with chopper), switches 1 to 3 are passed through and switch 4 is sent as 0.
- R6: With `topo_i` = 3 (no valid topology), every switch bit is sent as 0.
- R7: Each frame is 33 consecutive words with `valid_o` high. A new frame begins every `SLOT_CYCLES` clocks. The frame index runs 0, 1, 2, 3 and then repeats, and the first frame after reset has index 0.
- R8: `gate_i` and `topo_i` are captured on a clock edge at which `load_i` is high. A capture first shows in the next frame 0 header and then holds for the whole round. When several loads fall between two round starts, only the last one is used.
- R9: Submodules with an index at or above `ACTIVE_MODS` are always sent as zero.
- R10: `data_o` is zero whenever `valid_o` is low. During reset all outputs are zero. Until the first load, every payload word is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| load_i | input | 1 | Captures the command vector and the topology selector |
| topo_i | input | 2 | Submodule topology: 0 full, 1 half, 2 half with chopper, 3 none |
| gate_i | input | NUM_MOD*4 | Switch commands, one nibble per submodule |
| data_o | output | 32 | Frame word stream |
| valid_o | output | 1 | Word on `data_o` is part of a frame |
| sof_o | output | 1 | Word on `data_o` is a frame header |

## Verification
The first rounds after reset are checked to carry all-zero payloads. All-ones command vectors are then loaded under each of the four topology codes; each code leaves a distinct nibble value in every payload word, so a wrong bit mask or a swapped code shows up at once. Random vectors fill the nibbles with distinct data. This exposes any misplaced word, submodule or frame index, and with 1002 configured submodules it also checks the partly present word at the end of the populated range. Loads are placed in the middle of a round, and pairs of loads are issued within one round, so that a premature hand-over or a lost later load shows up as a mixed or stale round.

// File: rtl/swp_pkg.sv
package swp_pkg;

  localparam int unsigned WORD_W       = 32;
  localparam int unsigned IGBT_PER_MOD = 4;

  typedef enum logic [1:0] {
    TOPO_FULL      = 2'd0,
    TOPO_HALF      = 2'd1,
    TOPO_HALF_CHOP = 2'd2,
    TOPO_NONE      = 2'd3
  } topo_e;

  typedef struct packed {
    logic [11:0] addr;
    logic [11:0] wcount;
    logic [7:0]  ver;
  } hdr_t;

  // Switch bits kept for each topology; bit n-1 is switch n of a submodule
  function automatic logic [IGBT_PER_MOD-1:0] topo_mask(input topo_e t);
    logic [IGBT_PER_MOD-1:0] m;
    case (t)
      TOPO_FULL:      m = 4'b1111;
      TOPO_HALF:      m = 4'b0011;
      TOPO_HALF_CHOP: m = 4'b0111;
      default:        m = 4'b0000;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/swp_snapshot.sv
module swp_snapshot
  import swp_pkg::*;
#(
  parameter int unsigned NUM_MOD     = 1024,
  parameter int unsigned ACTIVE_MODS = NUM_MOD,
  parameter int unsigned VEC_W       = NUM_MOD * IGBT_PER_MOD
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            load_i,
  input  topo_e                           topo_i,
  input  logic [NUM_MOD*IGBT_PER_MOD-1:0] gate_i,
  input  logic                            swap_i,
  output logic [VEC_W-1:0]                active_o
);

  localparam int unsigned SLOTS = VEC_W / IGBT_PER_MOD;

  logic [IGBT_PER_MOD-1:0] keep;
  logic [VEC_W-1:0]        masked;
  logic [VEC_W-1:0]        shadow_q, shadow_n;
  logic [VEC_W-1:0]        active_q, active_n;

  assign keep = topo_mask(topo_i);

  // Per-submodule masking; slots beyond the configured count are tied off
  for (genvar m = 0; m < SLOTS; m++) begin : g_mod
    if ((m < NUM_MOD) && (m < ACTIVE_MODS)) begin : g_live
      assign masked[IGBT_PER_MOD*m +: IGBT_PER_MOD] =
        gate_i[IGBT_PER_MOD*m +: IGBT_PER_MOD] & keep;
    end else begin : g_absent
      assign masked[IGBT_PER_MOD*m +: IGBT_PER_MOD] = '0;
    end
  end

  always_comb begin
    shadow_n = shadow_q;
    active_n = active_q;
    if (load_i) shadow_n = masked;
    if (swap_i) active_n = shadow_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      active_q <= '0;
    end else begin
      if (load_i) shadow_q <= shadow_n;
      if (swap_i) active_q <= active_n;
    end
  end

  assign active_o = active_q;

endmodule

// File: rtl/swp_sequencer.sv
module swp_sequencer #(
  parameter int unsigned SLOT_CYCLES = 100,
  parameter int unsigned NUM_FRAMES  = 4,
  parameter int unsigned FRAME_WORDS = 33,
  parameter int unsigned SLOT_W      = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1,
  parameter int unsigned FRM_W       = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [SLOT_W-1:0] slot_o,
  output logic [FRM_W-1:0]  frame_o,
  output logic              emit_o,
  output logic              hdr_o,
  output logic              round_start_o
);

  logic [SLOT_W-1:0] slot_q, slot_n;
  logic [FRM_W-1:0]  frm_q, frm_n;
  logic              slot_end;

  assign slot_end = (slot_q == SLOT_W'(SLOT_CYCLES - 1));

  always_comb begin
    slot_n = slot_end ? '0 : slot_q + 1'b1;
    frm_n  = frm_q;
    if (slot_end) frm_n = (frm_q == FRM_W'(NUM_FRAMES - 1)) ? '0 : frm_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= '0;
      frm_q  <= '0;
    end else begin
      slot_q <= slot_n;
      frm_q  <= frm_n;
    end
  end

  assign slot_o        = slot_q;
  assign frame_o       = frm_q;
  assign emit_o        = (slot_q < SLOT_W'(FRAME_WORDS));
  assign hdr_o         = (slot_q == '0);
  assign round_start_o = (slot_q == '0) && (frm_q == '0);

endmodule

// File: rtl/swp_emitter.sv
module swp_emitter
  import swp_pkg::*;
#(
  parameter int unsigned NUM_FRAMES    = 4,
  parameter int unsigned PAYLOAD_WORDS = 32,
  parameter int unsigned SLOT_W        = 7,
  parameter int unsigned FRM_W         = 2,
  parameter logic [11:0] BASE_ADDR     = 12'h000,
  parameter logic [7:0]  VERSION       = 8'h01,
  parameter int unsigned TOTAL_WORDS   = NUM_FRAMES * PAYLOAD_WORDS,
  parameter int unsigned VEC_W         = TOTAL_WORDS * WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [FRM_W-1:0]  frame_i,
  input  logic              emit_i,
  input  logic              hdr_i,
  input  logic [VEC_W-1:0]  active_i,
  output logic [WORD_W-1:0] data_o,
  output logic              valid_o,
  output logic              sof_o
);

  localparam int unsigned IDX_W       = (TOTAL_WORDS > 1) ? $clog2(TOTAL_WORDS) : 1;
  localparam int unsigned FRAME_WORDS = PAYLOAD_WORDS + 1;

  logic [WORD_W-1:0] words [TOTAL_WORDS];
  logic [WORD_W-1:0] data_q, data_n;
  logic              valid_q, valid_n;
  logic              sof_q, sof_n;
  hdr_t              hdr;
  int                sel;

  for (genvar g = 0; g < TOTAL_WORDS; g++) begin : g_word
    assign words[g] = active_i[WORD_W*g +: WORD_W];
  end

  always_comb begin
    hdr.addr   = BASE_ADDR + 12'(frame_i);
    hdr.wcount = 12'(FRAME_WORDS);
    hdr.ver    = VERSION;
  end

  always_comb begin
    sel     = int'(frame_i) * int'(PAYLOAD_WORDS) + int'(slot_i) - 1;
    data_n  = '0;
    valid_n = emit_i;
    sof_n   = emit_i && hdr_i;
    if (emit_i) begin
      if (hdr_i) data_n = hdr;
      else       data_n = words[sel[IDX_W-1:0]];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      valid_q <= 1'b0;
      sof_q   <= 1'b0;
    end else begin
      data_q  <= data_n;
      valid_q <= valid_n;
      sof_q   <= sof_n;
    end
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;
  assign sof_o   = sof_q;

endmodule

// File: rtl/swp_frame_packer.sv
module swp_frame_packer
  import swp_pkg::*;
#(
  parameter int unsigned NUM_MOD       = 1024,
  parameter int unsigned ACTIVE_MODS   = NUM_MOD,
  parameter int unsigned PAYLOAD_WORDS = 32,
  parameter int unsigned SLOT_CYCLES   = 100,
  parameter logic [11:0] BASE_ADDR     = 12'h000,
  parameter logic [7:0]  VERSION       = 8'h01
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            load_i,
  input  logic [1:0]                      topo_i,
  input  logic [NUM_MOD*IGBT_PER_MOD-1:0] gate_i,
  output logic [WORD_W-1:0]               data_o,
  output logic                            valid_o,
  output logic                            sof_o
);

  localparam int unsigned MODS_PER_WORD  = WORD_W / IGBT_PER_MOD;
  localparam int unsigned MODS_PER_FRAME = MODS_PER_WORD * PAYLOAD_WORDS;
  localparam int unsigned NUM_FRAMES     = (NUM_MOD + MODS_PER_FRAME - 1) / MODS_PER_FRAME;
  localparam int unsigned FRAME_WORDS    = PAYLOAD_WORDS + 1;
  localparam int unsigned TOTAL_WORDS    = NUM_FRAMES * PAYLOAD_WORDS;
  localparam int unsigned VEC_W          = TOTAL_WORDS * WORD_W;
  localparam int unsigned SLOT_W         = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1;
  localparam int unsigned FRM_W          = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1;

  logic              rst_meta_q, rst_sync_q;
  logic [SLOT_W-1:0] slot;
  logic [FRM_W-1:0]  frame;
  logic              emit, hdr, round_start;
  logic [VEC_W-1:0]  active;

  // Reset asserts at once and releases two clocks later
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  swp_sequencer #(
    .SLOT_CYCLES (SLOT_CYCLES),
    .NUM_FRAMES  (NUM_FRAMES),
    .FRAME_WORDS (FRAME_WORDS),
    .SLOT_W      (SLOT_W),
    .FRM_W       (FRM_W)
  ) u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_sync_q),
    .slot_o        (slot),
    .frame_o       (frame),
    .emit_o        (emit),
    .hdr_o         (hdr),
    .round_start_o (round_start)
  );

  swp_snapshot #(
    .NUM_MOD     (NUM_MOD),
    .ACTIVE_MODS (ACTIVE_MODS),
    .VEC_W       (VEC_W)
  ) u_snap (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_q),
    .load_i   (load_i),
    .topo_i   (topo_e'(topo_i)),
    .gate_i   (gate_i),
    .swap_i   (round_start),
    .active_o (active)
  );

  swp_emitter #(
    .NUM_FRAMES    (NUM_FRAMES),
    .PAYLOAD_WORDS (PAYLOAD_WORDS),
    .SLOT_W        (SLOT_W),
    .FRM_W         (FRM_W),
    .BASE_ADDR     (BASE_ADDR),
    .VERSION       (VERSION),
    .TOTAL_WORDS   (TOTAL_WORDS),
    .VEC_W         (VEC_W)
  ) u_emit (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_q),
    .slot_i   (slot),
    .frame_i  (frame),
    .emit_i   (emit),
    .hdr_i    (hdr),
    .active_i (active),
    .data_o   (data_o),
    .valid_o  (valid_o),
    .sof_o    (sof_o)
  );

endmodule

// File: rtl/swp_frame_packer_chk.sv
module swp_frame_packer_chk #(
  parameter logic [11:0] BASE_ADDR   = 12'h000,
  parameter int unsigned NUM_FRAMES  = 4,
  parameter int unsigned FRAME_WORDS = 33
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] data_o,
  input logic        valid_o,
  input logic        sof_o
);

  // R1
  hdr_in_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |-> valid_o);

  // R1
  hdr_length_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |-> (data_o[19:8] == 12'(FRAME_WORDS)));

  // R7
  frame_index_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |-> (12'(data_o[31:20] - BASE_ADDR) < 12'(NUM_FRAMES)));

  // R7
  payload_follows_hdr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |=> (valid_o && !sof_o));

  // R7
  burst_opens_with_hdr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> sof_o);

  // R10
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (data_o == '0));

endmodule

bind swp_frame_packer swp_frame_packer_chk #(
  .BASE_ADDR   (BASE_ADDR),
  .NUM_FRAMES  (NUM_FRAMES),
  .FRAME_WORDS (FRAME_WORDS)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .data_o  (data_o),
  .valid_o (valid_o),
  .sof_o   (sof_o)
);

// File: tb/tb_swp_frame_packer.sv
module tb_swp_frame_packer;

  localparam int NM    = 1024;
  localparam int ACT   = 1002;
  localparam int SLOT  = 100;
  localparam int NF    = 4;
  localparam int PW    = 32;
  localparam int FW    = 33;
  localparam int VW    = NM * 4;
  localparam logic [11:0] BASE = 12'h3A0;
  localparam logic [7:0]  VER  = 8'h5C;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          load_i;
  logic [1:0]    topo_i;
  logic [VW-1:0] gate_i;
  logic [31:0]   data_o;
  logic          valid_o, sof_o;

  int checks = 0;
  int errors = 0;

  // Bench model state
  logic [VW-1:0] exp_shadow, exp_active;
  logic [1:0]    shadow_topo, active_topo;
  int            mon_frame = 0;
  int            widx = 0;
  int            since_sof = 0;
  int            run_len = 0;
  bit            seen_sof = 0;

  always #5 clk = ~clk;

  swp_frame_packer #(
    .NUM_MOD     (NM),
    .ACTIVE_MODS (ACT),
    .SLOT_CYCLES (SLOT),
    .BASE_ADDR   (BASE),
    .VERSION     (VER)
  ) dut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .load_i  (load_i),
    .topo_i  (topo_i),
    .gate_i  (gate_i),
    .data_o  (data_o),
    .valid_o (valid_o),
    .sof_o   (sof_o)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] keep_of(input logic [1:0] t);
    case (t)
      2'd0:    return 4'hF;
      2'd1:    return 4'h3;
      2'd2:    return 4'h7;
      default: return 4'h0;
    endcase
  endfunction

  function automatic logic [VW-1:0] model_snap(input logic [VW-1:0] g, input logic [1:0] t);
    logic [VW-1:0] r;
    r = '0;
    for (int m = 0; m < ACT; m++) r[4*m +: 4] = g[4*m +: 4] & keep_of(t);
    return r;
  endfunction

  function automatic string topo_tag(input logic [1:0] t);
    case (t)
      2'd0:    return "R3";
      2'd1:    return "R4";
      2'd2:    return "R5";
      default: return "R6";
    endcase
  endfunction

  // One clock: sample outputs at the falling edge and update the model
  task automatic step();
    int gw;
    logic [31:0] ew;
    @(negedge clk);
    since_sof++;
    if (!rst_n) begin
      check(data_o == 0 && !valid_o && !sof_o, "R10 reset", {data_o[31:2], valid_o, sof_o}, 32'h0);
    end else begin
      if (sof_o) begin
        if (seen_sof) check(since_sof == SLOT, "R7 slot spacing", since_sof, SLOT);
        mon_frame = seen_sof ? (mon_frame + 1) % NF : 0;
        seen_sof  = 1;
        since_sof = 0;
        widx      = 0;
        if (mon_frame == 0) begin
          exp_active  = exp_shadow;
          active_topo = shadow_topo;
        end
        check(data_o == {BASE + 12'(mon_frame), 12'(FW), VER}, "R1 R7 header", data_o,
              {BASE + 12'(mon_frame), 12'(FW), VER});
      end else if (valid_o) begin
        widx++;
        check(!sof_o, "R1 sof only on header", {31'd0, sof_o}, 32'd0);
        if (seen_sof && widx < FW) begin
          gw = mon_frame * PW + widx - 1;
          ew = exp_active[32*gw +: 32];
          if ((gw + 1) * 8 > ACT)
            check(data_o == ew, $sformatf("R2 R8 R9 frame %0d word %0d", mon_frame, widx), data_o, ew);
          else
            check(data_o == ew, $sformatf("R2 R8 %s frame %0d word %0d", topo_tag(active_topo),
                                          mon_frame, widx), data_o, ew);
        end
      end else begin
        check(data_o == 0, "R10 idle word", data_o, 32'd0);
      end
      if (valid_o) run_len++;
      else if (run_len != 0) begin
        check(run_len == FW, "R7 frame length", run_len, FW);
        run_len = 0;
      end
    end
    if (rst_n && load_i) begin
      exp_shadow  = model_snap(gate_i, topo_i);
      shadow_topo = topo_i;
    end
  endtask

  task automatic run(input int n);
    repeat (n) step();
  endtask

  task automatic do_load(input logic [VW-1:0] g, input logic [1:0] t);
    gate_i = g;
    topo_i = t;
    load_i = 1'b1;
    step();
    load_i = 1'b0;
  endtask

  task automatic wait_frame(input int f);
    step();
    while (!(sof_o && mon_frame == f)) step();
  endtask

  function automatic logic [VW-1:0] rand_vec();
    logic [VW-1:0] v;
    for (int i = 0; i < VW / 32; i++) v[32*i +: 32] = $urandom();
    return v;
  endfunction

  initial begin
    logic [VW-1:0] v;
    void'($urandom(32'd24681));
    rst_n = 1'b0; load_i = 1'b0; topo_i = 2'd0; gate_i = '0;
    exp_shadow = '0; exp_active = '0; shadow_topo = 2'd0; active_topo = 2'd0;
    fork
      begin
        run(6);
        rst_n = 1'b1;
        // R10: rounds before any load carry zero payloads
        run(2 * NF * SLOT);
        // R3..R6: all-ones under every topology code
        for (int t = 0; t < 4; t++) begin
          do_load({VW{1'b1}}, 2'(t));
          wait_frame(0);
          run(NF * SLOT);
        end
        // R2 R9: distinct random data, loaded mid-round
        for (int i = 0; i < 6; i++) begin
          run(1 + ($urandom() % 300));
          do_load(rand_vec(), 2'($urandom() % 4));
          wait_frame(0);
          run(NF * SLOT + 5);
        end
        // R8: two loads inside one round; the round in flight keeps old data
        wait_frame(2);
        v = rand_vec();
        do_load(v, 2'd0);
        wait_frame(3);
        do_load(~v, 2'd2);
        wait_frame(0);
        run(2 * NF * SLOT);
        // R8: load in the cycle right before a round start
        wait_frame(3);
        run(SLOT - 2);
        do_load(rand_vec(), 2'd0);
        run(2 * NF * SLOT);
      end
      begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule